// File: doc/BRIEF.md
# Local Bus Ready Generator

This block sits on the memory side of a 32-bit multiplexed address/data processor bus and drives the processor's active-low ready/recover input. It tracks each bus cycle from the address strobe and the burst-last strobe through address, data, wait, recovery, idle and hold phases. Ready is driven only in phases where the processor is allowed to see it.

The addressed slave is modelled by a wait count and a slave-ready level. Each data word of a burst of one to four words gets its own programmed number of wait cycles. In recovery, the ready pin has the opposite meaning: keeping it asserted extends recovery. The block asserts it for the programmed number of extra recovery cycles and then releases it so that recovery ends. The logic is strictly normally-not-ready. The output is a flop that changes only on the rising clock edge.

Top module: `ldrdy_gen`

## Requirements
- R1: When `ads_ni` is sampled low in the idle phase, the next cycle is the address phase (`phase_o` = 1), and the cycle after that is the first data phase (`phase_o` = 2).
- R2: `rdy_no` is never low in the address phase.
- R3: At the start of every data word the wait count `cfg_wait_i` (0 to 7) is loaded. With the slave ready, `rdy_no` goes low in data cycle number W of that word, counted from 0. W = 0 therefore gives ready in the first data cycle.
- R4: `rdy_no` goes low in a data cycle only if `slave_ready_i` was high in the cycle before it. Each data cycle without ready is one inserted wait cycle.
- R5: If `hold_i` is high in an idle cycle with no strobe, the next phase is hold (`phase_o` = 4). Hold lasts until `hold_i` is sampled low, and the phase after that is idle. `ads_ni` is ignored during hold, and `rdy_no` stays high.
- R6: A word that ends with `blast_ni` low is followed by the recovery phase (`phase_o` = 3), which lasts `cfg_recov_i` + 1 cycles (`cfg_recov_i` from 0 to 3). `rdy_no` is low in the first `cfg_recov_i` of those cycles and high in the last one. Idle follows.
- R7: `rdy_no` is never low in the idle phase, whatever the level of `slave_ready_i`.
- R8: While `rst_ni` is low, `rdy_no` is high and `phase_o` is idle (0).
- R9: A burst ends after its fourth terminated word and goes to recovery, even if `blast_ni` was never sampled low.
- R10: If `ads_ni` is low and `hold_i` is high in the same idle cycle, the bus cycle starts first. Hold is entered only after the cycle has returned to idle for one cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Bus clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| ads_ni | input | 1 | Address strobe from the processor, active low |
| blast_ni | input | 1 | Burst-last strobe from the processor, active low |
| hold_i | input | 1 | Bus handed to another master (hold request granted) |
| slave_ready_i | input | 1 | Addressed slave can complete the next data word |
| cfg_wait_i | input | 3 | Wait cycles per data word |
| cfg_recov_i | input | 2 | Extra recovery cycles |
| rdy_no | output | 1 | Ready/recover to the processor, active low, registered |
| phase_o | output | 3 | Current bus phase: 0 idle, 1 address, 2 data, 3 recovery, 4 hold |

## Verification
Two pairs of events can fall in the same cycle. The first is an address strobe and a hold request arriving together in idle. The bench raises `hold_i` in the same cycle as `ads_ni` and keeps it high for the whole burst. It then expects the full address, data and recovery sequence, one idle cycle, and only then the hold phase. The second is the slave becoming ready in the same cycle that the wait count runs out. The bench stalls the slave for more cycles than the wait count, fewer, and exactly as many. For each case, the model predicts the terminating cycle as the later of the two limits and compares the phase and ready on every clock.

// File: rtl/ldrdy_pkg.sv
package ldrdy_pkg;
  typedef enum logic [2:0] {
    PH_IDLE  = 3'd0,
    PH_ADDR  = 3'd1,
    PH_DATA  = 3'd2,
    PH_RECOV = 3'd3,
    PH_HOLD  = 3'd4
  } ldrdy_phase_e;
endpackage

// File: rtl/ldrdy_dncnt.sv
module ldrdy_dncnt #(
  parameter int W = 3
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic         load_i,
  input  logic [W-1:0] val_i,
  input  logic         dec_i,
  output logic         zero_o,
  output logic         nxt_zero_o
);
  logic [W-1:0] cnt_q, cnt_d;

  always_comb begin
    cnt_d = cnt_q;
    if (load_i)                    cnt_d = val_i;
    else if (dec_i && cnt_q != '0) cnt_d = cnt_q - W'(1);
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) cnt_q <= '0;
    else         cnt_q <= cnt_d;
  end

  assign zero_o     = (cnt_q == '0);
  assign nxt_zero_o = (cnt_d == '0);
endmodule

// File: rtl/ldrdy_fsm.sv
module ldrdy_fsm
  import ldrdy_pkg::*;
#(
  parameter int MAX_BEATS = 4
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic         ads_ni,
  input  logic         blast_ni,
  input  logic         hold_i,
  input  logic         rdy_i,
  input  logic         rcnt_zero_i,
  output ldrdy_phase_e phase_q_o,
  output ldrdy_phase_e phase_d_o,
  output logic         wload_o,
  output logic         wdec_o,
  output logic         rload_o,
  output logic         rdec_o
);
  localparam int BEAT_W = (MAX_BEATS > 1) ? $clog2(MAX_BEATS) : 1;

  ldrdy_phase_e st_q, st_d;
  logic [BEAT_W-1:0] beat_q, beat_d;
  logic last_word;

  assign last_word = !blast_ni || (beat_q == BEAT_W'(MAX_BEATS - 1));

  always_comb begin
    st_d    = st_q;
    beat_d  = beat_q;
    wload_o = 1'b0;
    wdec_o  = 1'b0;
    rload_o = 1'b0;
    rdec_o  = 1'b0;
    unique case (st_q)
      PH_IDLE: begin
        if (!ads_ni)     st_d = PH_ADDR;   // strobe wins over hold
        else if (hold_i) st_d = PH_HOLD;
      end
      PH_HOLD: if (!hold_i) st_d = PH_IDLE;
      PH_ADDR: begin
        st_d    = PH_DATA;
        wload_o = 1'b1;
        beat_d  = '0;
      end
      PH_DATA: begin
        if (rdy_i) begin
          if (last_word) begin
            st_d    = PH_RECOV;
            rload_o = 1'b1;
          end else begin
            wload_o = 1'b1;
            beat_d  = beat_q + BEAT_W'(1);
          end
        end else begin
          wdec_o = 1'b1;
        end
      end
      PH_RECOV: begin
        if (rcnt_zero_i) st_d = PH_IDLE;
        else             rdec_o = 1'b1;
      end
      default: st_d = PH_IDLE;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      st_q   <= PH_IDLE;
      beat_q <= '0;
    end else begin
      st_q   <= st_d;
      beat_q <= beat_d;
    end
  end

  assign phase_q_o = st_q;
  assign phase_d_o = st_d;
endmodule

// File: rtl/ldrdy_drv.sv
module ldrdy_drv
  import ldrdy_pkg::*;
(
  input  logic         clk_i,
  input  logic         rst_ni,
  input  ldrdy_phase_e phase_d_i,
  input  logic         wnxt_zero_i,
  input  logic         rnxt_zero_i,
  input  logic         slave_ready_i,
  output logic         rdy_o
);
  logic rdy_d, rdy_q;

  // normally not ready: only data and recovery may drive the pin
  always_comb begin
    unique case (phase_d_i)
      PH_DATA:  rdy_d = wnxt_zero_i && slave_ready_i;
      PH_RECOV: rdy_d = !rnxt_zero_i;
      default:  rdy_d = 1'b0;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) rdy_q <= 1'b0;
    else         rdy_q <= rdy_d;
  end

  assign rdy_o = rdy_q;
endmodule

// File: rtl/ldrdy_gen.sv
module ldrdy_gen
  import ldrdy_pkg::*;
#(
  parameter int WAIT_W    = 3,
  parameter int RECOV_W   = 2,
  parameter int MAX_BEATS = 4
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic               ads_ni,
  input  logic               blast_ni,
  input  logic               hold_i,
  input  logic               slave_ready_i,
  input  logic [WAIT_W-1:0]  cfg_wait_i,
  input  logic [RECOV_W-1:0] cfg_recov_i,
  output logic               rdy_no,
  output logic [2:0]         phase_o
);
  ldrdy_phase_e phase_q, phase_d;
  logic rdy, wload, wdec, rload, rdec;
  logic wzero, wnxt_zero, rzero, rnxt_zero;

  ldrdy_fsm #(.MAX_BEATS(MAX_BEATS)) u_fsm (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .ads_ni     (ads_ni),
    .blast_ni   (blast_ni),
    .hold_i     (hold_i),
    .rdy_i      (rdy),
    .rcnt_zero_i(rzero),
    .phase_q_o  (phase_q),
    .phase_d_o  (phase_d),
    .wload_o    (wload),
    .wdec_o     (wdec),
    .rload_o    (rload),
    .rdec_o     (rdec)
  );

  ldrdy_dncnt #(.W(WAIT_W)) u_wcnt (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .load_i    (wload),
    .val_i     (cfg_wait_i),
    .dec_i     (wdec),
    .zero_o    (wzero),
    .nxt_zero_o(wnxt_zero)
  );

  ldrdy_dncnt #(.W(RECOV_W)) u_rcnt (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .load_i    (rload),
    .val_i     (cfg_recov_i),
    .dec_i     (rdec),
    .zero_o    (rzero),
    .nxt_zero_o(rnxt_zero)
  );

  ldrdy_drv u_drv (
    .clk_i        (clk_i),
    .rst_ni       (rst_ni),
    .phase_d_i    (phase_d),
    .wnxt_zero_i  (wnxt_zero),
    .rnxt_zero_i  (rnxt_zero),
    .slave_ready_i(slave_ready_i),
    .rdy_o        (rdy)
  );

  logic unused_w;
  assign unused_w = wzero;

  assign rdy_no  = ~rdy;
  assign phase_o = phase_q;
endmodule

// File: rtl/ldrdy_chk.sv
module ldrdy_chk (
  input logic       clk_i,
  input logic       rst_ni,
  input logic       ads_ni,
  input logic       hold_i,
  input logic       slave_ready_i,
  input logic       rdy_no,
  input logic [2:0] phase_o
);
  logic [3:0] beats;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                         beats <= '0;
    else if (phase_o == 3'd0)            beats <= '0;
    else if (phase_o == 3'd2 && !rdy_no) beats <= beats + 4'd1;
  end

  assert_addr_start_R1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (phase_o == 3'd0 && !ads_ni) |=> phase_o == 3'd1);
  assert_addr_to_data_R1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    phase_o == 3'd1 |=> phase_o == 3'd2);
  assert_no_rdy_addr_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    phase_o == 3'd1 |-> rdy_no);
  assert_slave_gate_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (phase_o == 3'd2 && !rdy_no) |-> $past(slave_ready_i));
  assert_hold_quiet_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    phase_o == 3'd4 |-> rdy_no);
  assert_hold_exit_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (phase_o == 3'd4 && !hold_i) |=> phase_o == 3'd0);
  assert_recov_end_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (phase_o == 3'd3 && rdy_no) |=> phase_o == 3'd0);
  assert_no_rdy_idle_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    phase_o == 3'd0 |-> rdy_no);
  assert_beat_cap_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    phase_o == 3'd2 |-> beats < 4'd4);
endmodule

bind ldrdy_gen ldrdy_chk u_chk (
  .clk_i        (clk_i),
  .rst_ni       (rst_ni),
  .ads_ni       (ads_ni),
  .hold_i       (hold_i),
  .slave_ready_i(slave_ready_i),
  .rdy_no       (rdy_no),
  .phase_o      (phase_o)
);

// File: tb/ldrdy_gen_tb.sv
`timescale 1ns/1ps
module ldrdy_gen_tb_top;
  logic       clk_i = 1'b0;
  logic       rst_ni = 1'b0;
  logic       ads_ni = 1'b1;
  logic       blast_ni = 1'b1;
  logic       hold_i = 1'b0;
  logic       slave_ready_i = 1'b1;
  logic [2:0] cfg_wait_i = '0;
  logic [1:0] cfg_recov_i = '0;
  logic       rdy_no;
  logic [2:0] phase_o;

  int vectors = 0;
  int errors  = 0;
  bit done    = 0;

  localparam int IDLE = 0, ADDR = 1, DATA = 2, RECOV = 3, HOLD = 4;

  always #2.5 clk_i = ~clk_i;

  ldrdy_gen dut_i (
    .clk_i(clk_i), .rst_ni(rst_ni), .ads_ni(ads_ni), .blast_ni(blast_ni),
    .hold_i(hold_i), .slave_ready_i(slave_ready_i), .cfg_wait_i(cfg_wait_i),
    .cfg_recov_i(cfg_recov_i), .rdy_no(rdy_no), .phase_o(phase_o)
  );

  task automatic chk(input int ph, input bit rdy_n, input string req);
    vectors++;
    if (phase_o !== 3'(ph) || rdy_no !== rdy_n) begin
      errors++;
      $display("FAIL %s t=%0t phase/rdy_n actual %0d/%0b expected %0d/%0b",
               req, $time, phase_o, rdy_no, ph, rdy_n);
    end
  endtask

  // behavioural model: word ends at data cycle max(wait, stall)
  task automatic run_burst(input int n, input int w, input int r, input int st,
                           input bit blast_end, input bit hold_on);
    int wt;
    string dtag, rtag;
    wt   = (w > st) ? w : st;
    dtag = (st > 0) ? "R4" : "R3";
    rtag = blast_end ? "R6" : "R9";
    @(negedge clk_i); chk(IDLE, 1'b1, "R7");
    ads_ni = 1'b0; hold_i = hold_on; blast_ni = 1'b1;
    cfg_wait_i = 3'(w); cfg_recov_i = 2'(r);
    @(negedge clk_i); chk(ADDR, 1'b1, hold_on ? "R10" : "R1");
    ads_ni = 1'b1; slave_ready_i = (st == 0);
    for (int b = 0; b < n; b++) begin
      for (int j = 0; j <= wt; j++) begin
        @(negedge clk_i);
        chk(DATA, !(j == wt), (j == 0 && b == 0) ? "R1" : dtag);
        blast_ni = !(blast_end && b == n - 1);
        slave_ready_i = (j == wt) ? (st == 0) : (j + 1 >= st);
      end
    end
    for (int k = 0; k <= r; k++) begin
      @(negedge clk_i); chk(RECOV, !(k < r), rtag);
      blast_ni = 1'b1; slave_ready_i = 1'b1;
    end
  endtask

  initial begin
    #1; chk(IDLE, 1'b1, "R8");
    repeat (3) @(negedge clk_i);
    chk(IDLE, 1'b1, "R8");
    rst_ni = 1'b1;

    run_burst(1, 0, 0, 0, 1, 0);
    run_burst(4, 0, 0, 0, 1, 0);
    run_burst(2, 3, 1, 0, 1, 0);
    run_burst(3, 7, 3, 0, 1, 0);
    run_burst(2, 1, 2, 3, 1, 0);   // stall beyond wait count
    run_burst(2, 2, 0, 2, 1, 0);   // stall equal to wait count
    run_burst(4, 2, 1, 1, 0, 0);   // no burst-last: R9 cap
    for (int w = 0; w < 8; w++) run_burst((w % 4) + 1, w, w % 4, 0, 1, 0);

    // R5: hold, strobe ignored
    @(negedge clk_i); chk(IDLE, 1'b1, "R7"); hold_i = 1'b1;
    @(negedge clk_i); chk(HOLD, 1'b1, "R5"); ads_ni = 1'b0;
    @(negedge clk_i); chk(HOLD, 1'b1, "R5"); ads_ni = 1'b1; hold_i = 1'b0;
    @(negedge clk_i); chk(IDLE, 1'b1, "R5");

    // R10: strobe and hold in the same idle cycle
    run_burst(2, 1, 1, 0, 1, 1);
    @(negedge clk_i); chk(IDLE, 1'b1, "R10");
    @(negedge clk_i); chk(HOLD, 1'b1, "R10"); hold_i = 1'b0;
    @(negedge clk_i); chk(IDLE, 1'b1, "R5");

    // R7: slave ready level alone never drives ready in idle
    slave_ready_i = 1'b1;
    repeat (3) begin @(negedge clk_i); chk(IDLE, 1'b1, "R7"); end

    if (!done) begin
      done = 1;
      $display("== %0d vectors applied, %0d miscompares ==", vectors, errors);
      $finish;
    end
  end

  initial begin
    repeat (20000) @(posedge clk_i);
    if (!done) begin
      done = 1;
      errors++;
      $display("FAIL watchdog expired");
      $display("== %0d vectors applied, %0d miscompares ==", vectors, errors);
      $finish;
    end
  end
endmodule